// File: doc/BRIEF.md
# Prescaled PWM Channel with Synchronised Duty Update

This block is one pulse-width modulation channel behind a byte-wide register port. One of three slow source rates is picked by a clock-select field. Each source arrives as a one-cycle clock-enable tick on `src_tick_i`. The chosen rate is divided first by a predivider (1, 3, 5 or 6) and then by a power of two (2^0 to 2^7). Each resulting step advances a period counter that is either 6 or 9 bits wide. The output is high while the counter is below the programmed duty value.

Software writes size, clock, divider and duty settings into staged registers. Those settings have no effect on the output until a sync command copies them into the active set. When the glitch-free mode is off, a pending sync is applied on the next counter step. When it is on, the sync waits until the counter wraps to zero, so a period is never cut short. An enable bit starts and stops the channel. A read-only identifier tells the two register layouts apart: the full layout and a lite layout in which the size bit sits in a different position.

Top module: `synced_pwm`

## Requirements
- R1: After reset every register reads 0, except the identifier at 0x05, and `pwm_o` is low.
- R2: Register readback uses this layout. 0x41 holds size at bit 2 (bit 4 in the lite build) and clock select at bits 1:0. 0x42 holds the predivider code at bits 6:5 and the exponent at bits 2:0. 0x43 holds glitch-free mode at bit 5. 0x44 holds duty bits 7:0 and 0x45 holds duty bit 8 at bit 0. 0x46 holds enable at bit 7. All unused bits read 0, and 0x05 reads 0x0B (0x11 in the lite build).
- R3: The counter advances once per (predivider × 2^exponent) ticks of the selected source. Clock-select codes 1, 2 and 3 pick `src_tick_i` bits 0, 1 and 2. Predivider codes 0 to 3 divide by 1, 3, 5 and 6.
- R4: One period lasts 2^size counter steps, where size 0 means 6 bits and size 1 means 9 bits. The output is high while the counter is below the active duty value, so a duty of 0 gives a constant low.
- R5: A staged duty above 2^size − 1 is clamped to 2^size − 1 when it is transferred.
- R6: Writes to the staged registers do not change the output until a 1 is written to bit 0 of 0x47.
- R7: With glitch-free mode off, a pending sync takes effect on the next counter step.
- R8: With glitch-free mode on, a pending sync takes effect only when the counter wraps to 0.
- R9: While the channel is disabled, or while the active clock select is 0, a pending sync takes effect on the next clock cycle and restarts the period.
- R10: Clearing enable drives the output low and zeroes the counter and prescaler. Setting enable starts a fresh period at count 0.
- R11: With active clock-select code 0 the counter holds its value and the output stays low.
- R12: Reads of unimplemented addresses return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick_i | input | 3 | Clock-enable ticks of the three source rates (bit 0 slowest) |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_wr_i | input | 1 | Write strobe, one write per cycle it is high |
| reg_rdata_o | output | 8 | Combinational read data for `reg_addr_i` |
| pwm_o | output | 1 | PWM output |

## Verification
The assertions check a number of rules on every cycle. The output is low when the channel is disabled, when the clock select is 0, and when the duty is 0. The active duty never exceeds the size limit. The active set changes only while a sync is pending. In glitch-free mode a change of the active duty coincides with count 0. The identifier always reads back correctly.

Other behaviour only the bench scenarios can show. The bench runs a behavioural model alongside the design and checks the exact step rate for each source and divider. It also confirms the high-time fraction over whole periods, and that an output change after a sync comes immediately or is deferred, depending on the mode. It checks the length of the first high pulse after an enable, and that writes to unimplemented addresses leave the channel untouched.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
    localparam int unsigned BUS_W     = 8;
    localparam int unsigned DUTY_W    = 9;
    localparam int unsigned SMALL_W   = 6;
    localparam int unsigned CSEL_W    = 2;
    localparam int unsigned PDIV_W    = 2;
    localparam int unsigned EXP_W     = 3;
    localparam int unsigned NUM_SRC   = 3;
    localparam int unsigned PRE_CNT_W = 3;
    localparam int unsigned EXP_CNT_W = (1 << EXP_W) - 1;

    localparam logic [BUS_W-1:0] ADDR_ID      = 8'h05;
    localparam logic [BUS_W-1:0] ADDR_SIZECLK = 8'h41;
    localparam logic [BUS_W-1:0] ADDR_DIV     = 8'h42;
    localparam logic [BUS_W-1:0] ADDR_MODE    = 8'h43;
    localparam logic [BUS_W-1:0] ADDR_DUTY_LO = 8'h44;
    localparam logic [BUS_W-1:0] ADDR_DUTY_HI = 8'h45;
    localparam logic [BUS_W-1:0] ADDR_ENABLE  = 8'h46;
    localparam logic [BUS_W-1:0] ADDR_SYNC    = 8'h47;

    typedef struct packed {
        logic                wide;
        logic [CSEL_W-1:0]   csel;
        logic [PDIV_W-1:0]   pdiv;
        logic [EXP_W-1:0]    expo;
        logic [DUTY_W-1:0]   duty;
    } spwm_cfg_t;

    function automatic logic [PRE_CNT_W-1:0] pdiv_ratio(input logic [PDIV_W-1:0] code);
        case (code)
            2'd0:    return PRE_CNT_W'(1);
            2'd1:    return PRE_CNT_W'(3);
            2'd2:    return PRE_CNT_W'(5);
            default: return PRE_CNT_W'(6);
        endcase
    endfunction

    function automatic logic [DUTY_W-1:0] top_value(input logic wide);
        return wide ? DUTY_W'((1 << DUTY_W) - 1) : DUTY_W'((1 << SMALL_W) - 1);
    endfunction
endpackage

// File: rtl/spwm_regs.sv
module spwm_regs
    import spwm_pkg::*;
#(
    parameter bit LITE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] addr_i,
    input  logic [BUS_W-1:0] wdata_i,
    input  logic             wr_i,
    output spwm_cfg_t        staged_o,
    output logic             en_o,
    output logic             glitch_o,
    output logic             sync_req_o,
    output logic [BUS_W-1:0] rdata_o
);
    localparam int unsigned EN_BIT     = 7;
    localparam int unsigned GLITCH_BIT = 5;
    localparam int unsigned PDIV_LSB   = 5;
    localparam logic [BUS_W-1:0] ID_VAL = LITE ? 8'h11 : 8'h0B;

    typedef struct packed {
        spwm_cfg_t cfg;
        logic      en;
        logic      glitch;
    } regs_t;

    regs_t q, d;
    logic             size_in;
    logic [BUS_W-1:0] sizeclk_rd;

    // The register layout variant decides where the size bit lives.
    if (LITE) begin : g_lite_layout
        assign size_in    = wdata_i[4];
        assign sizeclk_rd = {3'b000, q.cfg.wide, 2'b00, q.cfg.csel};
    end else begin : g_full_layout
        assign size_in    = wdata_i[2];
        assign sizeclk_rd = {5'b00000, q.cfg.wide, q.cfg.csel};
    end

    always_comb begin
        d = q;
        if (wr_i) begin
            case (addr_i)
                ADDR_SIZECLK: begin
                    d.cfg.wide = size_in;
                    d.cfg.csel = wdata_i[CSEL_W-1:0];
                end
                ADDR_DIV: begin
                    d.cfg.pdiv = wdata_i[PDIV_LSB +: PDIV_W];
                    d.cfg.expo = wdata_i[EXP_W-1:0];
                end
                ADDR_MODE:    d.glitch            = wdata_i[GLITCH_BIT];
                ADDR_DUTY_LO: d.cfg.duty[7:0]     = wdata_i;
                ADDR_DUTY_HI: d.cfg.duty[DUTY_W-1] = wdata_i[0];
                ADDR_ENABLE:  d.en                = wdata_i[EN_BIT];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_ID:      rdata_o = ID_VAL;
            ADDR_SIZECLK: rdata_o = sizeclk_rd;
            ADDR_DIV:     rdata_o = {1'b0, q.cfg.pdiv, 2'b00, q.cfg.expo};
            ADDR_MODE:    rdata_o = {2'b00, q.glitch, 5'b00000};
            ADDR_DUTY_LO: rdata_o = q.cfg.duty[7:0];
            ADDR_DUTY_HI: rdata_o = {7'b0000000, q.cfg.duty[DUTY_W-1]};
            ADDR_ENABLE:  rdata_o = {q.en, 7'b0000000};
            default:      rdata_o = '0;
        endcase
    end

    assign sync_req_o = wr_i && (addr_i == ADDR_SYNC) && wdata_i[0];
    assign staged_o   = q.cfg;
    assign en_o       = q.en;
    assign glitch_o   = q.glitch;
endmodule

// File: rtl/spwm_prescale.sv
module spwm_prescale
    import spwm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_tick_i,
    input  logic [CSEL_W-1:0]  csel_i,
    input  logic [PDIV_W-1:0]  pdiv_i,
    input  logic [EXP_W-1:0]   expo_i,
    input  logic               clear_i,
    output logic               step_o
);
    typedef struct packed {
        logic [PRE_CNT_W-1:0] pre;
        logic [EXP_CNT_W-1:0] ex;
    } psc_t;

    psc_t q, d;
    logic                 tick_sel;
    logic [PRE_CNT_W-1:0] pre_last;
    logic [EXP_CNT_W:0]   exp_one_hot;
    logic [EXP_CNT_W-1:0] exp_last;

    always_comb begin
        tick_sel = 1'b0;
        if (csel_i != '0) tick_sel = src_tick_i[csel_i - 1'b1];
    end

    always_comb begin
        pre_last             = pdiv_ratio(pdiv_i) - 1'b1;
        exp_one_hot          = '0;
        exp_one_hot[expo_i]  = 1'b1;
        exp_last             = EXP_CNT_W'(exp_one_hot - 1'b1);
    end

    always_comb begin
        d      = q;
        step_o = 1'b0;
        if (clear_i) begin
            d = '0;
        end else if (tick_sel) begin
            if (q.pre == pre_last) begin
                d.pre = '0;
                if (q.ex == exp_last) begin
                    d.ex   = '0;
                    step_o = 1'b1;
                end else begin
                    d.ex = q.ex + 1'b1;
                end
            end else begin
                d.pre = q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/spwm_core.sv
module spwm_core
    import spwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  spwm_cfg_t         staged_i,
    input  logic              en_i,
    input  logic              glitch_i,
    input  logic              sync_req_i,
    input  logic              step_i,
    output spwm_cfg_t         act_o,
    output logic [DUTY_W-1:0] cnt_o,
    output logic              pend_o,
    output logic              clear_o,
    output logic              pwm_o
);
    typedef struct packed {
        spwm_cfg_t         act;
        logic [DUTY_W-1:0] cnt;
        logic              pend;
    } core_t;

    core_t q, d;
    logic [DUTY_W-1:0] top_act;
    logic [DUTY_W-1:0] top_staged;
    logic              wrap;
    logic              imm;
    logic              apply;

    always_comb begin
        top_act    = top_value(q.act.wide);
        top_staged = top_value(staged_i.wide);
        wrap       = step_i && (q.cnt >= top_act);
        imm        = q.pend && (!en_i || (q.act.csel == '0));
        apply      = imm || (q.pend && step_i && (!glitch_i || wrap));

        d      = q;
        d.pend = (q.pend && !apply) || sync_req_i;

        if (!en_i || imm)  d.cnt = '0;
        else if (step_i)   d.cnt = wrap ? '0 : q.cnt + 1'b1;

        if (apply) begin
            d.act = staged_i;
            if (staged_i.duty > top_staged) d.act.duty = top_staged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign clear_o = !en_i || imm;
    assign pwm_o   = en_i && (q.act.csel != '0) && (q.cnt < q.act.duty);
    assign act_o   = q.act;
    assign cnt_o   = q.cnt;
    assign pend_o  = q.pend;
endmodule

// File: rtl/synced_pwm.sv
module synced_pwm
    import spwm_pkg::*;
#(
    parameter bit LITE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       src_tick_i,
    input  logic [7:0]       reg_addr_i,
    input  logic [7:0]       reg_wdata_i,
    input  logic             reg_wr_i,
    output logic [7:0]       reg_rdata_o,
    output logic             pwm_o
);
    spwm_cfg_t         staged_w;
    spwm_cfg_t         act_w;
    logic              en_w;
    logic              glitch_w;
    logic              sync_req_w;
    logic              step_w;
    logic              clear_w;
    logic              pend_w;
    logic [DUTY_W-1:0] cnt_w;

    spwm_regs #(.LITE(LITE)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .wr_i       (reg_wr_i),
        .staged_o   (staged_w),
        .en_o       (en_w),
        .glitch_o   (glitch_w),
        .sync_req_o (sync_req_w),
        .rdata_o    (reg_rdata_o)
    );

    spwm_prescale u_psc (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_tick_i (src_tick_i),
        .csel_i     (act_w.csel),
        .pdiv_i     (act_w.pdiv),
        .expo_i     (act_w.expo),
        .clear_i    (clear_w),
        .step_o     (step_w)
    );

    spwm_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .staged_i   (staged_w),
        .en_i       (en_w),
        .glitch_i   (glitch_w),
        .sync_req_i (sync_req_w),
        .step_i     (step_w),
        .act_o      (act_w),
        .cnt_o      (cnt_w),
        .pend_o     (pend_w),
        .clear_o    (clear_w),
        .pwm_o      (pwm_o)
    );
endmodule

// File: rtl/spwm_checker.sv
module spwm_checker #(
    parameter bit LITE = 1'b0
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] addr,
    input logic [7:0] rdata,
    input logic       pwm,
    input logic       en,
    input logic       glitch,
    input logic [1:0] csel_act,
    input logic       wide_act,
    input logic [8:0] duty_act,
    input logic [8:0] cnt,
    input logic       pend
);
    localparam logic [7:0] ID_VAL = LITE ? 8'h11 : 8'h0B;

    p_id_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 8'h05) |-> (rdata == ID_VAL));

    p_zero_duty_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_act == 9'd0) |-> !pwm);

    p_duty_clamped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        duty_act <= (wide_act ? 9'd511 : 9'd63));

    p_sync_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |=> $stable(duty_act));

    p_wrap_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && glitch && en && (csel_act != 2'd0)) |=> ($stable(duty_act) || (cnt == 9'd0)));

    p_off_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !pwm);

    p_off_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == 9'd0));

    p_noclk_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (csel_act == 2'd0) |-> !pwm);

    p_noclk_halt_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (csel_act == 2'd0) && !pend) |=> (!en || $stable(cnt)));
endmodule

bind synced_pwm spwm_checker #(.LITE(LITE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (reg_addr_i),
    .rdata    (reg_rdata_o),
    .pwm      (pwm_o),
    .en       (en_w),
    .glitch   (glitch_w),
    .csel_act (act_w.csel),
    .wide_act (act_w.wide),
    .duty_act (act_w.duty),
    .cnt      (cnt_w),
    .pend     (pend_w)
);

// File: tb/synced_pwm_tb_top.sv
module synced_pwm_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] ticks = 3'b000;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic       wr = 1'b0;
    logic [7:0] rdata;
    logic       pwm;

    always #4 clk = ~clk;

    synced_pwm dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_tick_i  (ticks),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_wr_i    (wr),
        .reg_rdata_o (rdata),
        .pwm_o       (pwm)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Source ticks: bit2 every cycle, bit1 every 2nd, bit0 every 5th.
    int tcount = 0;
    always @(negedge clk) begin
        tcount++;
        ticks[2] = 1'b1;
        ticks[1] = (tcount % 2) == 0;
        ticks[0] = (tcount % 5) == 0;
    end

    // Behavioural reference model
    int m_wide, m_csel, m_pdiv, m_exp, m_duty, m_en, m_glitch;
    int a_wide, a_csel, a_pdiv, a_exp, a_duty;
    int m_pend, m_psc, m_cnt;

    function automatic int pd(input int c);
        case (c)
            0: return 1;
            1: return 3;
            2: return 5;
            default: return 6;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_wide = 0; m_csel = 0; m_pdiv = 0; m_exp = 0; m_duty = 0; m_en = 0; m_glitch = 0;
            a_wide = 0; a_csel = 0; a_pdiv = 0; a_exp = 0; a_duty = 0;
            m_pend = 0; m_psc = 0; m_cnt = 0;
        end else begin
            int ratio, tk, maxv, n_psc, n_cnt, n_pend, lim;
            bit step, imm, wrap, apply;
            ratio = pd(a_pdiv) << a_exp;
            tk    = (a_csel == 0) ? 0 : int'(ticks[a_csel-1]);
            imm   = m_pend && (!m_en || a_csel == 0);
            step  = 0;
            n_psc = m_psc;
            if (!m_en || imm) n_psc = 0;
            else if (tk != 0) begin
                if (m_psc + 1 >= ratio) begin n_psc = 0; step = 1; end
                else n_psc = m_psc + 1;
            end
            maxv  = a_wide ? 511 : 63;
            wrap  = step && (m_cnt >= maxv);
            apply = imm || (m_pend && step && (!m_glitch || wrap));
            if (!m_en || imm) n_cnt = 0;
            else if (step)    n_cnt = wrap ? 0 : m_cnt + 1;
            else              n_cnt = m_cnt;
            n_pend = ((m_pend && !apply) || (wr && addr == 8'h47 && wdata[0])) ? 1 : 0;
            if (apply) begin
                a_wide = m_wide; a_csel = m_csel; a_pdiv = m_pdiv; a_exp = m_exp;
                lim = m_wide ? 511 : 63;
                a_duty = (m_duty > lim) ? lim : m_duty;
            end
            if (wr) begin
                case (addr)
                    8'h41: begin m_wide = int'(wdata[2]); m_csel = int'(wdata[1:0]); end
                    8'h42: begin m_pdiv = int'(wdata[6:5]); m_exp = int'(wdata[2:0]); end
                    8'h43: m_glitch = int'(wdata[5]);
                    8'h44: m_duty = (m_duty & 256) | int'(wdata);
                    8'h45: m_duty = (m_duty & 255) | (int'(wdata[0]) << 8);
                    8'h46: m_en = int'(wdata[7]);
                    default: ;
                endcase
            end
            m_psc = n_psc; m_cnt = n_cnt; m_pend = n_pend;
        end
    end

    function automatic int exp_rd(input logic [7:0] a);
        case (a)
            8'h05: return 11;
            8'h41: return (m_wide << 2) | m_csel;
            8'h42: return (m_pdiv << 5) | m_exp;
            8'h43: return m_glitch << 5;
            8'h44: return m_duty & 255;
            8'h45: return m_duty >> 8;
            8'h46: return m_en << 7;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_pwm();
        return (m_en != 0 && a_csel != 0 && m_cnt < a_duty) ? 1 : 0;
    endfunction

    // Per-cycle comparison against the model, away from the clock edge.
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            chk("R4 pwm level vs model", int'(pwm), exp_pwm());
            chk("R2 read data vs model", int'(rdata), exp_rd(addr));
        end
    end

    task automatic wrreg(input logic [7:0] a, input logic [7:0] dv);
        @(negedge clk);
        addr = a; wdata = dv; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rdreg(input logic [7:0] a, output int v);
        @(negedge clk);
        addr = a; wr = 1'b0;
        #2 v = int'(rdata);
    endtask

    task automatic count_high(input int n, output int h);
        h = 0;
        repeat (n) begin
            @(negedge clk);
            #1 if (pwm) h++;
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_fall();
        int guard = 0;
        @(negedge clk);
        #1;
        while (!pwm && guard < 2000) begin @(negedge clk); #1; guard++; end
        while (pwm && guard < 2000) begin @(negedge clk); #1; guard++; end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run hung actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int v, h;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1 chk("R1 pwm low after reset", int'(pwm), 0);
        for (int a = 8'h41; a <= 8'h47; a++) begin
            rdreg(8'(a), v);
            chk("R1 register zero after reset", v, 0);
        end
        rdreg(8'h05, v);
        chk("R2 identifier", v, 8'h0B);

        // R2: field masks
        wrreg(8'h42, 8'hFF); rdreg(8'h42, v); chk("R2 divider fields", v, 8'h67);
        wrreg(8'h41, 8'hFF); rdreg(8'h41, v); chk("R2 size/clock fields", v, 8'h07);
        wrreg(8'h45, 8'hFF); rdreg(8'h45, v); chk("R2 duty high bit", v, 8'h01);
        wrreg(8'h43, 8'hFF); rdreg(8'h43, v); chk("R2 glitch bit", v, 8'h20);
        wrreg(8'h46, 8'hFF); rdreg(8'h46, v); chk("R2 enable bit", v, 8'h80);
        rdreg(8'h47, v); chk("R2 sync reads zero", v, 0);
        wrreg(8'h43, 8'h00); wrreg(8'h45, 8'h00);

        // R4: 6-bit, fastest source, duty 16
        wrreg(8'h41, 8'h03); wrreg(8'h42, 8'h00); wrreg(8'h44, 8'd16);
        wrreg(8'h46, 8'h80); wrreg(8'h47, 8'h01);
        wait_cycles(70);
        count_high(128, h); chk("R4 duty 16 of 64", h, 32);

        // R3: middle source, then divider 3 x 2^1, then slowest source
        wrreg(8'h41, 8'h02); wrreg(8'h47, 8'h01);
        wait_cycles(140);
        count_high(128, h); chk("R3 source code 2", h, 32);
        wrreg(8'h41, 8'h03); wrreg(8'h42, 8'h21); wrreg(8'h44, 8'd32); wrreg(8'h47, 8'h01);
        wait_cycles(400);
        count_high(384, h); chk("R3 predivider 3 exponent 1", h, 192);
        wrreg(8'h41, 8'h01); wrreg(8'h42, 8'h00); wrreg(8'h44, 8'd16); wrreg(8'h47, 8'h01);
        wait_cycles(340);
        count_high(320, h); chk("R3 source code 1", h, 80);
        wrreg(8'h41, 8'h03); wrreg(8'h47, 8'h01);
        wait_cycles(70);

        // R6: staged writes without sync
        wrreg(8'h44, 8'd48); wrreg(8'h45, 8'h00);
        count_high(128, h); chk("R6 no change before sync", h, 32);
        rdreg(8'h44, v); chk("R2 staged duty readback", v, 48);

        // R5: clamp in 6-bit mode
        wrreg(8'h44, 8'd100); wrreg(8'h47, 8'h01);
        wait_cycles(70);
        count_high(64, h); chk("R5 clamp to 63", h, 63);

        // R4: 9-bit mode
        wrreg(8'h41, 8'h07); wrreg(8'h45, 8'h01); wrreg(8'h44, 8'h00); wrreg(8'h47, 8'h01);
        wait_cycles(520);
        count_high(512, h); chk("R4 9-bit duty 256", h, 256);
        wrreg(8'h44, 8'hFF); wrreg(8'h47, 8'h01);
        wait_cycles(520);
        count_high(512, h); chk("R4 9-bit duty 511", h, 511);
        wrreg(8'h45, 8'h00); wrreg(8'h44, 8'h00); wrreg(8'h47, 8'h01);
        wait_cycles(520);
        count_high(512, h); chk("R4 duty zero stays low", h, 0);

        // R7: glitch-free off, sync lands on next step
        wrreg(8'h41, 8'h03); wrreg(8'h44, 8'd10); wrreg(8'h47, 8'h01);
        wait_cycles(70);
        wrreg(8'h44, 8'd60);
        wait_fall();
        wait_cycles(3);
        wrreg(8'h47, 8'h01);
        wait_cycles(4);
        #1 chk("R7 immediate duty change", int'(pwm), 1);

        // R8: glitch-free on, sync deferred to wrap
        wrreg(8'h44, 8'd10); wrreg(8'h47, 8'h01);
        wait_cycles(70);
        wrreg(8'h43, 8'h20); wrreg(8'h44, 8'd60);
        wait_fall();
        wait_cycles(3);
        wrreg(8'h47, 8'h01);
        wait_cycles(4);
        #1 chk("R8 change deferred", int'(pwm), 0);
        wait_cycles(80);
        count_high(64, h); chk("R8 applied after wrap", h, 60);

        // R9: sync while disabled applies at once
        wrreg(8'h46, 8'h00); wrreg(8'h44, 8'd20); wrreg(8'h47, 8'h01);
        wrreg(8'h46, 8'h80);
        count_high(64, h); chk("R9 disabled sync immediate", h, 20);

        // R10: disable forces low, enable restarts period
        wrreg(8'h46, 8'h00);
        #1 chk("R10 low when disabled", int'(pwm), 0);
        wait_cycles(5);
        #1 chk("R10 stays low", int'(pwm), 0);
        wrreg(8'h46, 8'h80);
        #1;
        h = 0;
        while (pwm && h < 1000) begin h++; @(negedge clk); #1; end
        chk("R10 first pulse length", h, 20);

        // R11: clock select 0
        wrreg(8'h41, 8'h00); wrreg(8'h47, 8'h01);
        wait_cycles(80);
        count_high(64, h); chk("R11 no clock output low", h, 0);
        rdreg(8'h41, v); chk("R11 clock select readback", v, 0);

        // R12: unimplemented addresses
        wrreg(8'h41, 8'h03); wrreg(8'h47, 8'h01);
        wait_cycles(10);
        wrreg(8'h50, 8'hFF); wrreg(8'h00, 8'hFF);
        rdreg(8'h50, v); chk("R12 unimplemented read", v, 0);
        rdreg(8'h44, v); chk("R12 duty untouched", v, 20);
        rdreg(8'h41, v); chk("R12 size/clock untouched", v, 3);
        rdreg(8'h43, v); chk("R12 mode untouched", v, 8'h20);
        count_high(64, h); chk("R12 output untouched", h, 20);

        summary();
        $finish;
    end
endmodule